// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller, a host processor and a small local RAM. The controller issues 24-bit addresses. The host also reaches the same RAM through this block. Every access, from either side, is sent through a shared table of 1024 slots. Each slot is 16 bits wide and names a physical page frame, a byte order and a memory location.

The low ten address bits pass through as the offset inside a 1 KiB page. The next ten bits pick a slot, and the top four bits are dropped. The block returns the physical address, which is the frame number followed by the offset. It also returns a memory-select bit, an on-board RAM enable, a lane-swap indication and an out-of-range flag.

The host programs and inspects the table through a simple indexed port. Several slots may name one frame. The usual setup gives the top slot the same frame as slot 0, so that a structure fixed near the top of the controller's space is stored in low RAM.

Top module: `pagemap_xlate`

## Requirements
- R1: Address bits 23:20 have no effect. Two requests that differ only in those bits give identical results.
- R2: A request accepted on a clock edge gives results one cycle later, and the valid output is high in that cycle:
  - the slot is address bits 19:10;
  - the physical address is {entry bits 11:0, address bits 9:0}.
- R3: A map write stores map_wdata_i in slot map_idx_i. A map read returns the stored slot on map_rdata_o one cycle later. A read of a slot in the same cycle as a write to it returns the old contents.
- R4: A translation in the same cycle as a map write to its slot uses the old entry. The next translation uses the new one.
- R5: After reset every slot reads zero, so every address then maps to frame 0 in on-board RAM with controller byte order.
- R6: The memory-select output equals entry bit 13 (1 = auxiliary bus, 0 = on-board). The on-board RAM enable is high only when bit 13 is 0 and the frame is in range.
- R7: An on-board access whose frame (entry bits 11:0) is 256 or more sets the out-of-range flag and clears the RAM enable. An auxiliary-bus access never sets the flag.
- R8: On the controller channel, a full 16-bit access (both strobes, be = 2'b11) asks for a lane swap exactly when entry bit 15 is 1 (host big-endian order).
- R9: On the host channel, a full 16-bit access asks for a lane swap exactly when entry bit 15 is 0 (controller little-endian order).
- R10: A partial access (be other than 2'b11) never asks for a lane swap.
- R11: Slots that hold the same frame give the same physical page. Slot 1023 set to frame 0 maps address 24'hFFFFF4 to physical 22'h0003F4.
- R12: In a cycle with no valid result, all result flags are zero:
  - the RAM enable;
  - the memory select;
  - the lane swap;
  - the out-of-range flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_wr_i | input | 1 | Host map write strobe |
| map_rd_i | input | 1 | Host map read strobe |
| map_idx_i | input | 10 | Map slot index |
| map_wdata_i | input | 16 | Map write data |
| map_rdata_o | output | 16 | Map read data, one cycle after read |
| c_req_i | input | 1 | Controller translation request |
| c_addr_i | input | 24 | Controller address |
| c_be_i | input | 2 | Controller byte strobes |
| c_vld_o | output | 1 | Controller result valid |
| c_paddr_o | output | 22 | Controller physical address |
| c_aux_o | output | 1 | Controller memory select (1 = auxiliary bus) |
| c_ram_en_o | output | 1 | Controller on-board RAM enable |
| c_swap_o | output | 1 | Controller byte-lane swap |
| c_oor_o | output | 1 | Controller frame out of range |
| h_req_i | input | 1 | Host translation request |
| h_addr_i | input | 24 | Host address |
| h_be_i | input | 2 | Host byte strobes |
| h_vld_o | output | 1 | Host result valid |
| h_paddr_o | output | 22 | Host physical address |
| h_aux_o | output | 1 | Host memory select (1 = auxiliary bus) |
| h_ram_en_o | output | 1 | Host on-board RAM enable |
| h_swap_o | output | 1 | Host byte-lane swap |
| h_oor_o | output | 1 | Host frame out of range |

## Verification
A corrupted or stale slot shows up one cycle after the next translation that selects it. It appears as a wrong page frame in the physical address, a flipped memory select or a lane swap inverted for one channel. The same slot also reads back wrong on the map port one cycle after a read. Because both channels see the same slot, a fault in the shared storage appears on both channels at once. A fault in a single channel's decode appears on that channel only.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int FRAME_W = 12;
  localparam int ENT_W   = 16;

  // Field positions are fixed by software that builds map entries.
  typedef struct packed {
    logic               big;    // 15: host byte order
    logic               rsv14;
    logic               aux;    // 13: auxiliary bus
    logic               rsv12;
    logic [FRAME_W-1:0] frame;  // 11:0
  } map_ent_t;

  localparam logic [1:0] BE_FULL = 2'b11;
endpackage

// File: rtl/pmx_map_store.sv
module pmx_map_store
  import pmx_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int NPORT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [SLOT_W-1:0] idx_i,
  input  map_ent_t          wdata_i,
  output map_ent_t          rdata_o,
  input  logic [SLOT_W-1:0] xslot_i [NPORT],
  output map_ent_t          xent_o  [NPORT]
);
  localparam int SLOTS = 1 << SLOT_W;

  map_ent_t mem [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i) mem[idx_i] <= wdata_i;
      if (rd_i) rdata_o <= mem[idx_i];
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_xrd
    assign xent_o[g] = mem[xslot_i[g]];
  end

  // R3/R4: a write lands in the addressed slot
  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem[$past(idx_i)] == $past(wdata_i));

  // R3: read returns the pre-edge slot contents
  a_r3_read_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_o == $past(mem[idx_i]));
endmodule

// File: rtl/pmx_xlate_lane.sv
module pmx_xlate_lane
  import pmx_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int OFF_W         = 10,
  parameter int SLOT_W        = 10,
  parameter int ONBOARD_PAGES = 256,
  parameter bit NATIVE_BIG    = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [1:0]               be_i,
  output logic [SLOT_W-1:0]        slot_o,
  input  map_ent_t                 ent_i,
  output logic                     vld_o,
  output logic [FRAME_W+OFF_W-1:0] paddr_o,
  output logic                     aux_o,
  output logic                     ram_en_o,
  output logic                     swap_o,
  output logic                     oor_o
);
  localparam int HI_LSB = OFF_W + SLOT_W;

  logic oor_c, swap_c;
  logic unused_bits;

  assign slot_o = addr_i[OFF_W +: SLOT_W];
  // top address bits and reserved entry bits take no part
  assign unused_bits = ^addr_i[ADDR_W-1:HI_LSB] ^ ent_i.rsv14 ^ ent_i.rsv12;

  always_comb begin
    oor_c  = !ent_i.aux && (ent_i.frame >= FRAME_W'(ONBOARD_PAGES));
    swap_c = (be_i == BE_FULL) && (ent_i.big != NATIVE_BIG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      paddr_o  <= '0;
      aux_o    <= 1'b0;
      ram_en_o <= 1'b0;
      swap_o   <= 1'b0;
      oor_o    <= 1'b0;
    end else if (req_i) begin
      vld_o    <= 1'b1;
      paddr_o  <= {ent_i.frame, addr_i[OFF_W-1:0]};
      aux_o    <= ent_i.aux;
      ram_en_o <= !ent_i.aux && !oor_c;
      swap_o   <= swap_c;
      oor_o    <= oor_c;
    end else begin
      vld_o    <= 1'b0;
      paddr_o  <= '0;
      aux_o    <= 1'b0;
      ram_en_o <= 1'b0;
      swap_o   <= 1'b0;
      oor_o    <= 1'b0;
    end
  end

  a_r2_vld_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);

  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> paddr_o[OFF_W-1:0] == $past(addr_i[OFF_W-1:0]));

  a_r10_partial_no_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != BE_FULL) |=> !swap_o);

  a_r7_oor_onboard_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> (!ram_en_o && !aux_o));

  a_r6_ram_needs_onboard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> !aux_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> !(ram_en_o || aux_o || swap_o || oor_o));
endmodule

// File: rtl/pagemap_xlate.sv
module pagemap_xlate
  import pmx_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int OFF_W         = 10,
  parameter int SLOT_W        = 10,
  parameter int ONBOARD_PAGES = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     map_wr_i,
  input  logic                     map_rd_i,
  input  logic [SLOT_W-1:0]        map_idx_i,
  input  logic [ENT_W-1:0]         map_wdata_i,
  output logic [ENT_W-1:0]         map_rdata_o,
  input  logic                     c_req_i,
  input  logic [ADDR_W-1:0]        c_addr_i,
  input  logic [1:0]               c_be_i,
  output logic                     c_vld_o,
  output logic [FRAME_W+OFF_W-1:0] c_paddr_o,
  output logic                     c_aux_o,
  output logic                     c_ram_en_o,
  output logic                     c_swap_o,
  output logic                     c_oor_o,
  input  logic                     h_req_i,
  input  logic [ADDR_W-1:0]        h_addr_i,
  input  logic [1:0]               h_be_i,
  output logic                     h_vld_o,
  output logic [FRAME_W+OFF_W-1:0] h_paddr_o,
  output logic                     h_aux_o,
  output logic                     h_ram_en_o,
  output logic                     h_swap_o,
  output logic                     h_oor_o
);
  localparam int NCH     = 2;
  localparam int PADDR_W = FRAME_W + OFF_W;

  logic                req_v   [NCH];
  logic [ADDR_W-1:0]   addr_v  [NCH];
  logic [1:0]          be_v    [NCH];
  logic [SLOT_W-1:0]   slot_v  [NCH];
  map_ent_t            ent_v   [NCH];
  logic                vld_v   [NCH];
  logic [PADDR_W-1:0]  paddr_v [NCH];
  logic                aux_v   [NCH];
  logic                ram_v   [NCH];
  logic                swap_v  [NCH];
  logic                oor_v   [NCH];
  map_ent_t            rdata_s;

  assign req_v[0]  = c_req_i;
  assign addr_v[0] = c_addr_i;
  assign be_v[0]   = c_be_i;
  assign req_v[1]  = h_req_i;
  assign addr_v[1] = h_addr_i;
  assign be_v[1]   = h_be_i;

  pmx_map_store #(.SLOT_W(SLOT_W), .NPORT(NCH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (map_wr_i),
    .rd_i    (map_rd_i),
    .idx_i   (map_idx_i),
    .wdata_i (map_ent_t'(map_wdata_i)),
    .rdata_o (rdata_s),
    .xslot_i (slot_v),
    .xent_o  (ent_v)
  );

  assign map_rdata_o = rdata_s;

  // channel 0 is the controller (little-endian), channel 1 the host (big-endian)
  for (genvar g = 0; g < NCH; g++) begin : g_lane
    pmx_xlate_lane #(
      .ADDR_W        (ADDR_W),
      .OFF_W         (OFF_W),
      .SLOT_W        (SLOT_W),
      .ONBOARD_PAGES (ONBOARD_PAGES),
      .NATIVE_BIG    (g == 1)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_v[g]),
      .addr_i   (addr_v[g]),
      .be_i     (be_v[g]),
      .slot_o   (slot_v[g]),
      .ent_i    (ent_v[g]),
      .vld_o    (vld_v[g]),
      .paddr_o  (paddr_v[g]),
      .aux_o    (aux_v[g]),
      .ram_en_o (ram_v[g]),
      .swap_o   (swap_v[g]),
      .oor_o    (oor_v[g])
    );
  end

  assign c_vld_o    = vld_v[0];
  assign c_paddr_o  = paddr_v[0];
  assign c_aux_o    = aux_v[0];
  assign c_ram_en_o = ram_v[0];
  assign c_swap_o   = swap_v[0];
  assign c_oor_o    = oor_v[0];
  assign h_vld_o    = vld_v[1];
  assign h_paddr_o  = paddr_v[1];
  assign h_aux_o    = aux_v[1];
  assign h_ram_en_o = ram_v[1];
  assign h_swap_o   = swap_v[1];
  assign h_oor_o    = oor_v[1];

  // R8/R9: one full access on both channels through one slot swaps on exactly one side
  a_r8_r9_opposite_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_req_i && h_req_i && c_be_i == BE_FULL && h_be_i == BE_FULL &&
     c_addr_i[OFF_W +: SLOT_W] == h_addr_i[OFF_W +: SLOT_W])
    |=> (c_swap_o != h_swap_o));
endmodule

// File: tb/pagemap_xlate_test.sv
module pagemap_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_wr = 0, map_rd = 0;
  logic [9:0]  map_idx = '0;
  logic [15:0] map_wdata = '0;
  logic [15:0] map_rdata;
  logic        c_req = 0, h_req = 0;
  logic [23:0] c_addr = '0, h_addr = '0;
  logic [1:0]  c_be = '0, h_be = '0;
  logic        c_vld, c_aux, c_ram, c_swap, c_oor;
  logic        h_vld, h_aux, h_ram, h_swap, h_oor;
  logic [21:0] c_paddr, h_paddr;

  always #10 clk = ~clk;

  pagemap_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .map_wr_i(map_wr), .map_rd_i(map_rd), .map_idx_i(map_idx),
    .map_wdata_i(map_wdata), .map_rdata_o(map_rdata),
    .c_req_i(c_req), .c_addr_i(c_addr), .c_be_i(c_be),
    .c_vld_o(c_vld), .c_paddr_o(c_paddr), .c_aux_o(c_aux),
    .c_ram_en_o(c_ram), .c_swap_o(c_swap), .c_oor_o(c_oor),
    .h_req_i(h_req), .h_addr_i(h_addr), .h_be_i(h_be),
    .h_vld_o(h_vld), .h_paddr_o(h_paddr), .h_aux_o(h_aux),
    .h_ram_en_o(h_ram), .h_swap_o(h_swap), .h_oor_o(h_oor)
  );

  typedef struct {
    logic [26:0] res;   // {vld, paddr, aux, ram_en, swap, oor}
    string       tag;
  } exp_t;

  typedef struct {
    bit          rd;
    logic [15:0] data;
    string       tag;
  } rexp_t;

  exp_t  cq[$];
  exp_t  hq[$];
  rexp_t rq[$];
  logic [15:0] model [1024];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [26:0] predict(bit host, bit r, logic [23:0] a, logic [1:0] be);
    logic [15:0] e;
    logic oor, aux, swp;
    if (!r) return '0;
    e   = model[a[19:10]];
    aux = e[13];
    oor = !aux && (e[11:0] >= 12'd256);
    swp = (be == 2'b11) && (host ? !e[15] : e[15]);
    return {1'b1, e[11:0], a[9:0], aux, !aux && !oor, swp, oor};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [9:0] idx, logic [15:0] wd,
                     bit cr, logic [23:0] ca, logic [1:0] cb,
                     bit hr, logic [23:0] ha, logic [1:0] hb, string tag);
    exp_t  ec, eh;
    rexp_t er;
    @(negedge clk);
    map_wr = wr; map_rd = rd; map_idx = idx; map_wdata = wd;
    c_req = cr; c_addr = ca; c_be = cb;
    h_req = hr; h_addr = ha; h_be = hb;
    ec.res = predict(0, cr, ca, cb); ec.tag = tag;
    eh.res = predict(1, hr, ha, hb); eh.tag = tag;
    er.rd = rd; er.data = model[idx]; er.tag = tag;
    cq.push_back(ec); hq.push_back(eh); rq.push_back(er);
    if (wr) model[idx] = wd;
  endtask

  task automatic wmap(logic [9:0] i, logic [15:0] d, string tag);
    cyc(1, 0, i, d, 0, '0, 2'b00, 0, '0, 2'b00, tag);
  endtask

  task automatic rmap(logic [9:0] i, string tag);
    cyc(0, 1, i, '0, 0, '0, 2'b00, 0, '0, 2'b00, tag);
  endtask

  task automatic xl(logic [23:0] ca, logic [1:0] cb, logic [23:0] ha, logic [1:0] hb, string tag);
    cyc(0, 0, '0, '0, 1, ca, cb, 1, ha, hb, tag);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, '0, '0, 0, '0, 2'b00, 0, '0, 2'b00, tag);
  endtask

  // monitor: outputs settle after the posedge, compared mid-phase
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (cq.size() > 0) begin
        exp_t e;
        e = cq.pop_front();
        check(e.tag, "ctl", {5'd0, c_vld, c_paddr, c_aux, c_ram, c_swap, c_oor}, {5'd0, e.res});
      end
      if (hq.size() > 0) begin
        exp_t e;
        e = hq.pop_front();
        check(e.tag, "host", {5'd0, h_vld, h_paddr, h_aux, h_ram, h_swap, h_oor}, {5'd0, e.res});
      end
      if (rq.size() > 0) begin
        rexp_t r;
        r = rq.pop_front();
        if (r.rd) check(r.tag, "rdata", {16'd0, map_rdata}, {16'd0, r.data});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R5: outputs quiet during reset
    check("R5", "reset outs", {20'd0, c_vld, c_ram, c_swap, c_oor, h_vld, h_ram, h_swap, h_oor, map_rdata[3:0]}, 32'd0);
    rst_n = 1'b1;
    idle("R12");
    // R5: all slots zero after reset
    rmap(10'd0, "R5");
    rmap(10'd1023, "R5");
    rmap(10'd517, "R5");
    // R5/R9: zero entry -> frame 0, little order; host full access swaps
    xl(24'h123456, 2'b11, 24'h00ABCD, 2'b11, "R5_R9");
    idle("R12");
    // program the map
    wmap(10'd1,    16'h8005, "R3");
    wmap(10'd2,    16'h0007, "R3");
    wmap(10'd3,    16'h2123, "R3");
    wmap(10'd4,    16'h0100, "R3");
    wmap(10'd5,    16'h00FF, "R3");
    wmap(10'd6,    16'h5FFF, "R3");
    wmap(10'd7,    16'hA300, "R3");
    wmap(10'd1023, 16'h8000, "R11");
    for (int i = 1; i < 8; i++) rmap(10'(i), "R3");
    rmap(10'd1023, "R3");
    // R3: read and write of same slot in one cycle returns old value
    cyc(1, 1, 10'd5, 16'h00FE, 0, '0, 2'b00, 0, '0, 2'b00, "R3");
    rmap(10'd5, "R3");
    // R2/R8: big-endian page, full access swaps on controller only
    xl(24'h000412, 2'b11, 24'h0007FE, 2'b11, "R8");
    // R1: top nibble ignored
    xl(24'hF00412, 2'b11, 24'hA007FE, 2'b11, "R1");
    xl(24'h500BFF, 2'b11, 24'h900800, 2'b11, "R1");
    // R10: partial accesses never swap
    xl(24'h000412, 2'b01, 24'h000800, 2'b10, "R10");
    xl(24'h000413, 2'b10, 24'h000C00, 2'b01, "R10");
    xl(24'h000414, 2'b00, 24'h000415, 2'b00, "R10");
    // R6: auxiliary-bus page
    xl(24'h000C01, 2'b11, 24'h000FFF, 2'b11, "R6");
    xl(24'h001C00, 2'b11, 24'h001C10, 2'b01, "R6");
    // R7: frame 256 and 0xFFF on-board are out of range; aux with high frame is not
    xl(24'h001000, 2'b11, 24'h0013FF, 2'b11, "R7");
    xl(24'h001800, 2'b11, 24'h001A5A, 2'b10, "R7");
    xl(24'h000C00, 2'b01, 24'h001400, 2'b11, "R7");
    // R11: top slot aliases frame 0
    xl(24'hFFFFF4, 2'b11, 24'h0003F4, 2'b11, "R11");
    xl(24'h0FFFF4, 2'b01, 24'hFFFFF4, 2'b11, "R11");
    // R4: same-cycle write uses old entry, next cycle new
    cyc(1, 0, 10'd2, 16'h80C8, 1, 24'h000900, 2'b11, 1, 24'h000901, 2'b11, "R4");
    xl(24'h000900, 2'b11, 24'h000901, 2'b11, "R4");
    cyc(1, 0, 10'd2, 16'h2001, 1, 24'h000933, 2'b11, 0, '0, 2'b00, "R4");
    cyc(0, 0, '0, '0, 0, '0, 2'b00, 1, 24'h000933, 2'b11, "R4");
    // R12: one-sided requests leave the other channel quiet
    cyc(0, 0, '0, '0, 1, 24'h000555, 2'b11, 0, '0, 2'b00, "R12");
    cyc(0, 0, '0, '0, 0, '0, 2'b00, 1, 24'h000555, 2'b11, "R12");
    idle("R12");
    // R2: sweep slots with frames derived from index
    for (int i = 16; i < 48; i++) wmap(10'(i), 16'((i * 37) & 16'hB1FF), "R2");
    for (int i = 16; i < 48; i++)
      xl({4'h3, 10'(i), 10'(i * 11)}, 2'(i), {4'hC, 10'(63 - i), 10'(i * 5)}, 2'b11, "R2");
    idle("R12");
    idle("R12");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule